// File: doc/BRIEF.md
# Key-Dependent Subkey Expansion Sequencer

This block builds the key-dependent working memories of a 64-bit Feistel block cipher: an 18-word round-subkey array followed by four 256-word substitution tables, 1042 words of 32 bits in all. The caller loads a secret key of 4 to 56 bytes through a narrow port, 64 bits at a time, and then pulses `start` with the key length. The sequencer first copies fixed initial constants from an external constant port into every memory word. It then folds the key into the 18 subkeys. Last, it drives an external round engine 521 times, chaining each ciphertext into the next request and writing every result back into the memories, two words per result.

All memory traffic leaves the block through a single write port, one 32-bit word per clock. The round engine reads the same memories and so always sees the subkeys and tables updated so far. The constant port and the round engine sit outside this block.

Top module: `subkey_expander`

## Requirements
- R1: Out of reset `ready` is 1, and `mem_we` and `eng_req` are 0.
- R2: Key chunk `key_idx` (0 to 6) is written when `key_wr` is high while `ready` is 1. Key byte n is held in chunk n/8, and byte 0 of a chunk is bits 63:56.
- R3: A `start` with `key_bytes` below 4 or above 56 is ignored: `ready` stays 1 and no memory write takes place.
- R4: An accepted start first writes addresses 0 to 1041 in ascending order, one per clock in consecutive cycles. Each word is the `rom_data` returned for `rom_addr` equal to that address.
- R5: Next, address i (0 to 17) is rewritten with its initial constant XOR a 32-bit key word. The word is made of key bytes (4i+k) mod `key_bytes` for k = 0..3, with k = 0 placed in the most significant byte.
- R6: The first engine request carries an all-zero block. `eng_req` stays high until `eng_ack` is seen.
- R7: Each engine result goes to a pair of addresses, walked from 0 to 1041 in order, in two consecutive cycles. Bits 63:32 go to the lower address and bits 31:0 to the next one. The next request carries that result.
- R8: `ready` is 0 from the cycle after an accepted start until the final write to address 1041, and it is 1 again in the following cycle. Exactly 521 engine requests are made.
- R9: While `ready` is 0, both `start` and key chunk writes are ignored, and the memory contents left at the end are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_wr | input | 1 | Key chunk write strobe |
| key_idx | input | 3 | Key chunk index |
| key_chunk | input | 64 | Key chunk data |
| key_bytes | input | 7 | Key length in bytes, sampled at start |
| start | input | 1 | Begin expansion |
| ready | output | 1 | Idle, expansion complete |
| rom_addr | output | 11 | Initial-constant address |
| rom_data | input | 32 | Initial constant for `rom_addr`, same cycle |
| eng_req | output | 1 | Encryption request to round engine |
| eng_blk | output | 64 | Plaintext block for round engine |
| eng_ack | input | 1 | One-cycle completion pulse from engine |
| eng_res | input | 64 | Ciphertext, valid with `eng_ack` |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 11 | Memory word address (0-17 subkeys, 18-1041 tables) |
| mem_wdata | output | 32 | Memory write data |

## Verification
The assertions assume that the round engine raises `eng_ack` only while `eng_req` is high, for one cycle, with `eng_res` valid in that cycle. They also assume that `rom_data` settles within the cycle of its address. The bench's engine model answers a request after a few cycles and then drops `eng_ack` before the sequencer can raise `eng_req` again, and its constant port is a combinational function of the address. The length seen by the key-pointer check is the one latched at start, and the bench keeps it within 4 to 56 for accepted runs.

// File: rtl/subkey_pkg.sv
package subkey_pkg;
  localparam int SUBKEYS     = 18;
  localparam int TABLES      = 4;
  localparam int TBL_DEPTH   = 256;
  localparam int WORDS       = SUBKEYS + TABLES * TBL_DEPTH;
  localparam int ADDR_W      = $clog2(WORDS);
  localparam int WORD_W      = 32;
  localparam int BLK_W       = 2 * WORD_W;
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int CHUNK_W     = 64;
  localparam int CHUNK_BYTES = CHUNK_W / 8;
  localparam int CB_W        = $clog2(CHUNK_BYTES);
  localparam int MIN_BYTES   = 4;
  localparam int MAX_BYTES   = 56;
  localparam int CHUNKS      = (MAX_BYTES + CHUNK_BYTES - 1) / CHUNK_BYTES;
  localparam int POS_W       = $clog2(MAX_BYTES);
  localparam int LEN_W       = POS_W + 1;
  localparam int CIDX_W      = POS_W - CB_W;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_MIX, S_REQ, S_WL, S_WR
  } seq_state_e;
endpackage

// File: rtl/subkey_keystore.sv
module subkey_keystore
  import subkey_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CIDX_W-1:0]  wr_idx,
  input  logic [CHUNK_W-1:0] wr_data,
  input  logic [LEN_W-1:0]   len,
  input  logic               restart,
  input  logic               adv,
  output logic [WORD_W-1:0]  word
);
  logic [CHUNK_W-1:0] chunk_q [CHUNKS];
  logic [POS_W-1:0]   ptr_q, ptr_d;
  logic [POS_W-1:0]   pos [WORD_BYTES];
  logic [LEN_W-1:0]   step, wrapped;

  assign pos[0] = ptr_q;

  // one byte picker per byte of the assembled word, positions wrap at len
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
    logic [CIDX_W-1:0]  ci;
    logic [CB_W-1:0]    bi;
    logic [CHUNK_W-1:0] sh;
    assign ci = pos[k][POS_W-1:CB_W];
    assign bi = pos[k][CB_W-1:0];
    assign sh = chunk_q[ci] << {bi, 3'b000};
    assign word[WORD_W-1-8*k -: 8] = sh[CHUNK_W-1 -: 8];
    if (k < WORD_BYTES - 1) begin : g_next
      logic [LEN_W-1:0] inc;
      assign inc = {1'b0, pos[k]} + 1'b1;
      assign pos[k+1] = (inc >= len) ? '0 : inc[POS_W-1:0];
    end
  end

  assign step    = {1'b0, ptr_q} + LEN_W'(WORD_BYTES);
  assign wrapped = (step >= len) ? step - len : step;

  always_comb begin
    ptr_d = ptr_q;
    if (restart)  ptr_d = '0;
    else if (adv) ptr_d = wrapped[POS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < CHUNKS; i++) chunk_q[i] <= '0;
    end else begin
      if (restart || adv) ptr_q <= ptr_d;
      for (int i = 0; i < CHUNKS; i++)
        if (wr_en && wr_idx == CIDX_W'(i)) chunk_q[i] <= wr_data;
    end
  end

  // R5: byte pointer stays inside the key after every advance
  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ({1'b0, ptr_q} < len));
endmodule

// File: rtl/subkey_wport.sv
module subkey_wport
  import subkey_pkg::*;
(
  input  seq_state_e        st,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [WORD_W-1:0] rom_word,
  input  logic [WORD_W-1:0] key_word,
  input  logic [BLK_W-1:0]  blk,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] wdata
);
  always_comb begin
    we    = 1'b0;
    addr  = ptr;
    wdata = '0;
    case (st)
      S_LOAD: begin we = 1'b1; wdata = rom_word;            end
      S_MIX:  begin we = 1'b1; wdata = rom_word ^ key_word; end
      S_WL:   begin we = 1'b1; wdata = blk[BLK_W-1:WORD_W]; end
      S_WR:   begin we = 1'b1; addr = ptr + 1'b1; wdata = blk[WORD_W-1:0]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/subkey_expander.sv
module subkey_expander
  import subkey_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               key_wr,
  input  logic [CIDX_W-1:0]  key_idx,
  input  logic [CHUNK_W-1:0] key_chunk,
  input  logic [LEN_W-1:0]   key_bytes,
  input  logic               start,
  output logic               ready,
  output logic [ADDR_W-1:0]  rom_addr,
  input  logic [WORD_W-1:0]  rom_data,
  output logic               eng_req,
  output logic [BLK_W-1:0]   eng_blk,
  input  logic               eng_ack,
  input  logic [BLK_W-1:0]   eng_res,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0]  mem_wdata
);
  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [BLK_W-1:0]  blk_q, blk_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              len_ok, accept, reg_en;
  logic [WORD_W-1:0] key_word;

  assign len_ok = (key_bytes >= LEN_W'(MIN_BYTES)) && (key_bytes <= LEN_W'(MAX_BYTES));
  assign ready  = (state_q == S_IDLE);
  assign accept = ready && start && len_ok;

  subkey_keystore u_keys (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (key_wr && ready),
    .wr_idx  (key_idx),
    .wr_data (key_chunk),
    .len     (len_q),
    .restart (accept),
    .adv     (state_q == S_MIX),
    .word    (key_word)
  );

  subkey_wport u_wport (
    .st       (state_q),
    .ptr      (ptr_q),
    .rom_word (rom_data),
    .key_word (key_word),
    .blk      (blk_q),
    .we       (mem_we),
    .addr     (mem_addr),
    .wdata    (mem_wdata)
  );

  assign rom_addr = ptr_q;
  assign eng_req  = (state_q == S_REQ);
  assign eng_blk  = blk_q;

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    blk_d   = blk_q;
    len_d   = len_q;
    case (state_q)
      S_IDLE: if (accept) begin
        state_d = S_LOAD; ptr_d = '0; blk_d = '0; len_d = key_bytes;
      end
      S_LOAD: if (ptr_q == ADDR_W'(WORDS - 1)) begin
        state_d = S_MIX; ptr_d = '0;
      end else ptr_d = ptr_q + 1'b1;
      S_MIX: if (ptr_q == ADDR_W'(SUBKEYS - 1)) begin
        state_d = S_REQ; ptr_d = '0;
      end else ptr_d = ptr_q + 1'b1;
      S_REQ: if (eng_ack) begin
        state_d = S_WL; blk_d = eng_res;
      end
      S_WL: state_d = S_WR;
      S_WR: if (ptr_q == ADDR_W'(WORDS - 2)) begin
        state_d = S_IDLE; ptr_d = '0;
      end else begin
        state_d = S_REQ; ptr_d = ptr_q + ADDR_W'(2);
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign reg_en = (state_q != S_IDLE) || accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      blk_q   <= '0;
      len_q   <= '0;
    end else if (reg_en) begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      blk_q   <= blk_d;
      len_q   <= len_d;
    end
  end

  // R1: an idle sequencer neither writes nor requests
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!mem_we && !eng_req));
  // R4: writes stay inside the 1042-word space
  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr < ADDR_W'(WORDS)));
  // R6: a request is held until acknowledged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> eng_req);
  // R7: the left half of a result is written in the cycle after the ack
  p_left_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_ack) |=> (mem_we && mem_wdata == $past(eng_res[BLK_W-1:WORD_W])));
  // R7: the right half lands one address above the left half
  p_pair_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WL) |=> (mem_we && mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: tb/sim_subkey_expander.sv
module sim_subkey_expander;
  import subkey_pkg::*;
  localparam int LOGN = 2 * WORDS + SUBKEYS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_wr = 1'b0;
  logic [CIDX_W-1:0] key_idx = '0;
  logic [CHUNK_W-1:0] key_chunk = '0;
  logic [LEN_W-1:0] key_bytes = '0;
  logic start = 1'b0;
  logic ready;
  logic [ADDR_W-1:0] rom_addr;
  logic [WORD_W-1:0] rom_data;
  logic eng_req;
  logic [BLK_W-1:0] eng_blk;
  logic eng_ack = 1'b0;
  logic [BLK_W-1:0] eng_res = '0;
  logic mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata;

  always #10 clk = ~clk;

  subkey_expander u0 (.*);

  int n_chk = 0, n_bad = 0;
  int cyc = 0, wn = 0, base = 0, n_enc = 0, enc_base = 0, cnt = 0;
  bit done = 0;
  logic [BLK_W-1:0]  first_blk;
  logic [WORD_W-1:0] bmem [WORDS];
  logic [WORD_W-1:0] refm [WORDS];
  logic [WORD_W-1:0] refmix [SUBKEYS];
  logic [ADDR_W-1:0] wa [LOGN];
  logic [WORD_W-1:0] wd [LOGN];
  int                wc [LOGN];
  logic [7:0]        key_b [MAX_BYTES];

  function automatic logic [WORD_W-1:0] romf(input int a);
    logic [WORD_W-1:0] v;
    v = WORD_W'(a) * 32'h9E3779B9;
    return v ^ 32'h243F6A88;
  endfunction

  assign rom_data = romf(int'(rom_addr));

  function automatic logic [WORD_W-1:0] mget(input int a, input bit use_ref);
    return use_ref ? refm[a] : bmem[a];
  endfunction

  // toy round engine: depends on the block and on current subkeys and tables
  function automatic logic [BLK_W-1:0] toy(input logic [BLK_W-1:0] b, input bit use_ref);
    logic [WORD_W-1:0] hi, lo;
    hi = b[31:0] ^ mget(0, use_ref) ^ mget(18 + int'(b[7:0]), use_ref)
         ^ mget(274 + int'(b[15:8]), use_ref);
    lo = b[63:32] + mget(17, use_ref) + mget(WORDS - 1, use_ref);
    return {hi, lo};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_we) begin
      bmem[mem_addr] <= mem_wdata;
      if (wn - base < LOGN) begin
        wa[wn - base] <= mem_addr;
        wd[wn - base] <= mem_wdata;
        wc[wn - base] <= cyc;
      end
      wn <= wn + 1;
    end
  end

  always @(negedge clk) begin
    if (eng_ack) eng_ack <= 1'b0;
    else if (rst_n && eng_req) begin
      if (cnt == 2) begin
        if (n_enc == enc_base) first_blk <= eng_blk;
        eng_res <= toy(eng_blk, 1'b0);
        eng_ack <= 1'b1;
        n_enc   <= n_enc + 1;
        cnt     <= 0;
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ready === 1'b1, "R1", "ready in reset", 64'(ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1, "R1", "ready after reset", 64'(ready), 64'd1);
    chk(mem_we === 1'b0 && eng_req === 1'b0, "R1", "write/request idle",
        64'({mem_we, eng_req}), 64'd0);
  endtask

  task automatic t_bad_len(input int len);
    int b0;
    bit stay;
    b0 = wn;
    stay = 1;
    key_bytes = LEN_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (ready !== 1'b1) stay = 0;
      @(negedge clk);
    end
    chk(stay, "R3", $sformatf("ready held, len %0d", len), 64'(stay), 64'd1);
    chk(wn == b0, "R3", $sformatf("no writes, len %0d", len), 64'(wn - b0), 64'd0);
  endtask

  task automatic t_expand(input int len, input int seed, input bit disturb);
    int e_load, e_mix, e_ord, e_pair, e_fin, kw_pos;
    logic [BLK_W-1:0] b;
    logic [WORD_W-1:0] w;
    string tag;
    tag = disturb ? "R9" : "R7";
    for (int n = 0; n < MAX_BYTES; n++) key_b[n] = 8'(seed * 31 + n * 7 + (n >> 1));
    for (int c = 0; c < CHUNKS; c++) begin
      key_wr = 1'b1;
      key_idx = CIDX_W'(c);
      for (int j = 0; j < CHUNK_BYTES; j++)
        key_chunk[CHUNK_W-1-8*j -: 8] = key_b[c * CHUNK_BYTES + j];
      @(negedge clk);
    end
    key_wr = 1'b0;
    // reference model built from the requirements
    for (int a = 0; a < WORDS; a++) refm[a] = romf(a);
    for (int i = 0; i < SUBKEYS; i++) begin
      for (int k = 0; k < 4; k++) begin
        kw_pos = (4 * i + k) % len;
        w[31-8*k -: 8] = key_b[kw_pos];
      end
      refm[i] = refm[i] ^ w;
      refmix[i] = refm[i];
    end
    b = '0;
    for (int p = 0; p < WORDS; p += 2) begin
      b = toy(b, 1'b1);
      refm[p] = b[63:32];
      refm[p+1] = b[31:0];
    end
    base = wn;
    enc_base = n_enc;
    key_bytes = LEN_W'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ready === 1'b0, "R8", "ready low after start", 64'(ready), 64'd0);
    if (disturb) begin
      repeat (5) @(negedge clk);
      key_wr = 1'b1; key_idx = '0; key_chunk = ~key_chunk;
      key_bytes = LEN_W'(20); start = 1'b1;
      @(negedge clk);
      key_wr = 1'b0; start = 1'b0;
    end
    while (wn - base < LOGN) @(negedge clk);
    if (!(wn - base == LOGN && ready === 1'b1)) @(negedge clk);
    chk(ready === 1'b1 && wa[LOGN-1] == ADDR_W'(WORDS - 1), "R8",
        "ready back after last write", 64'(ready), 64'd1);
    e_load = 0; e_mix = 0; e_ord = 0; e_pair = 0; e_fin = 0;
    for (int n = 0; n < WORDS; n++)
      if (wa[n] != ADDR_W'(n) || wd[n] != romf(n) || wc[n] != wc[0] + n) e_load++;
    chk(e_load == 0, "R4", "initial load order/data/timing", 64'(e_load), 64'd0);
    for (int i = 0; i < SUBKEYS; i++)
      if (wa[WORDS+i] != ADDR_W'(i) || wd[WORDS+i] != refmix[i]) e_mix++;
    chk(e_mix == 0, "R2 R5", $sformatf("key mix words, len %0d", len), 64'(e_mix), 64'd0);
    for (int n = 0; n < WORDS; n++)
      if (wa[WORDS+SUBKEYS+n] != ADDR_W'(n)) e_ord++;
    for (int n = 0; n < WORDS; n += 2)
      if (wc[WORDS+SUBKEYS+n+1] != wc[WORDS+SUBKEYS+n] + 1) e_pair++;
    chk(e_ord == 0 && e_pair == 0, "R7", "write-back order and pairing",
        64'(e_ord + e_pair), 64'd0);
    chk(n_enc - enc_base == WORDS / 2, "R8", "engine request count",
        64'(n_enc - enc_base), 64'(WORDS / 2));
    chk(first_blk == '0, "R6", "first block all zero", first_blk, 64'd0);
    for (int a = 0; a < WORDS; a++) if (bmem[a] != refm[a]) e_fin++;
    chk(e_fin == 0, tag, $sformatf("final memory, len %0d", len), 64'(e_fin), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < WORDS; a++) bmem[a] = '0;
    t_reset();
    t_bad_len(3);
    t_bad_len(57);
    t_expand(56, 1, 1'b0);
    t_expand(5, 2, 1'b0);
    t_expand(4, 3, 1'b1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule